// File: doc/BRIEF.md
# SPI Slave Packet Framing and Acknowledge Engine

This block sits behind a single-line SPI slave byte shifter. In the default clock setting the shifter idles its clock low and samples on the leading edge. The shifter is outside this block. Received bytes arrive one per `rx_valid` strobe while `sel_active` shows that slave select is asserted. A receive parser recognises packets made of a sync byte (0x5A), a command byte, a serial-number byte, a 16-bit size (high byte first), the payload and a 16-bit checksum (high byte first). It forwards payload bytes as they arrive. After the last checksum byte it raises either a good pulse or an error pulse. A consumer discards the payload it has collected when the error pulse arrives.

A transmit framer produces the bytes that the shifter sends back. It is a pull interface: `tx_byte` holds the current byte, and `tx_take` advances to the next one. Every transmission begins with one 0x00 byte that the master discards. A good packet in full mode queues an acknowledge frame. That frame echoes the received serial number, has size zero and uses the command code `ACK_CMD`. Outgoing data packets use the same header, and their serial number comes from an internal counter. The two-bit `mode` selects one of three settings:
- 0: full protocol.
- 1: framing without acknowledge.
- 2 or 3: raw pass-through, with no sync, header or checksum in either direction.

Parser states:
- RX_SYNC waits for the sync byte.
- RX_CMD, RX_SN, RX_LHI and RX_LLO take the header. RX_LLO goes to RX_DATA, goes to RX_CKH when the size is zero, or goes back to RX_SYNC when the size is larger than `MAX_LEN`.
- RX_DATA counts the payload.
- RX_CKH and RX_CKL take the checksum, then return to RX_SYNC.
- Deasserting slave select in any state returns the parser to RX_SYNC.

Framer states:
- TX_IDLE loads an acknowledge first, or else a data request, and moves to TX_LEAD.
- TX_LEAD sends the 0x00 byte. It goes to TX_DATA or TX_IDLE in raw mode, and to TX_SYNC otherwise.
- TX_SYNC, TX_CMD, TX_SN, TX_LHI, TX_LLO, TX_DATA, TX_CKH and TX_CKL each advance on `tx_take`. TX_CKL returns to TX_IDLE.

Top module: `spp_link`

## Requirements
- R1: In a framed mode (mode 0 or 1) a packet is 0x5A, command, serial number, size high, size low, payload, checksum high, checksum low. Each payload byte appears on `pay_valid`/`pay_byte` one cycle after it is received. No header or checksum byte is forwarded.
- R2: The checksum is the 16-bit wrapping sum of all bytes from 0x5A through the last payload byte. When it matches, `pkt_ok` pulses for one cycle, one cycle after the low checksum byte, with `pkt_cmd` and `pkt_sn` holding the packet's command and serial number.
- R3: `pkt_err` pulses for one cycle, and `pkt_ok` stays low, in three cases. The first is a byte other than 0x5A received while waiting for sync. The second is a checksum mismatch, reported one cycle after the low checksum byte. The third is a size larger than `MAX_LEN`, reported one cycle after the low size byte; the parser then waits for sync again.
- R4: In mode 0 a good packet queues an acknowledge frame: 0x00, 0x5A, `ACK_CMD` (default 0xAC), the received serial number, 0x00, 0x00, then the checksum of bytes 0x5A through the second size byte, high byte first.
- R5: In mode 1 packets are parsed and checked as in R1 to R3, but no acknowledge is queued and `tx_busy` stays low.
- R6: In mode 2 or 3 every byte received under select is forwarded on `pay_valid`, and `pkt_ok`/`pkt_err` never pulse. An accepted transmit request sends 0x00 followed only by the `tx_len` payload bytes.
- R7: A data frame accepted in a framed mode is sent as 0x00, 0x5A, `tx_cmd`, serial number, size high, size low, payload (`tx_pay_byte` at index `tx_pay_idx`), checksum high, checksum low. The serial number is 0 after reset and rises by one per framed data frame, wrapping after 255. Raw frames do not advance it.
- R8: When an acknowledge is pending and `tx_go` is also high, the acknowledge frame is sent first. `tx_accept` pulses only when the framer is idle and no acknowledge is pending. It is followed on the next cycle by `tx_busy` high with `tx_byte` = 0x00.
- R9: Deasserting `sel_active` aborts a partly received packet with no pulse, and the next packet parses from its sync byte.
- R10: After reset `tx_busy` is low, `tx_byte` is 0xFF (the idle filler, present whenever `tx_busy` is low), and `pay_valid`, `pkt_ok` and `pkt_err` are low.
- R11: While `tx_busy` is high and `tx_take` is low, `tx_byte` holds its value. A frame ends with `tx_busy` low after the last byte is taken.
- R12: A packet of size zero has its checksum right after the size bytes and is accepted when the checksum is correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 full protocol, 1 no acknowledge, 2/3 raw |
| sel_active | input | 1 | Slave select asserted |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| pay_valid | output | 1 | Forwarded payload byte strobe |
| pay_byte | output | 8 | Forwarded payload byte |
| pkt_ok | output | 1 | Good packet pulse |
| pkt_err | output | 1 | Dropped packet pulse |
| pkt_cmd | output | 8 | Command of the last good packet |
| pkt_sn | output | 8 | Serial number of the last good packet |
| tx_go | input | 1 | Request to send a data frame |
| tx_cmd | input | 8 | Command for the data frame |
| tx_len | input | 16 | Payload size of the data frame |
| tx_accept | output | 1 | Data request taken this cycle |
| tx_take | input | 1 | Shifter consumed `tx_byte` |
| tx_byte | output | 8 | Current byte to transmit |
| tx_busy | output | 1 | Frame in progress |
| tx_pay_idx | output | 16 | Index of the payload byte wanted |
| tx_pay_byte | input | 8 | Payload byte at `tx_pay_idx` |

## Verification
The assertions check on every cycle that `pkt_ok` and `pkt_err` are never high together and that raw mode never pulses either. They also check that forwarded bytes and results always follow a received byte, and that a deasserted select blocks all outputs on the next cycle. On the transmit side they check that an accepted request starts with the 0x00 lead byte, that the filler appears whenever the framer is idle, and that the byte holds until it is taken. Only the bench scenarios can show that checksum arithmetic, acknowledge contents, serial-number wrap and acknowledge precedence are correct. The same holds for recovery after an aborted or oversized packet, because each needs whole byte sequences compared against computed frames.

// File: rtl/spp_pkg.sv
package spp_pkg;
    localparam int          LEN_W     = 16;
    localparam logic [7:0]  SYNC_BYTE = 8'h5A;
    localparam logic [7:0]  LEAD_BYTE = 8'h00;
    localparam logic [7:0]  FILL_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        MODE_FULL  = 2'd0,
        MODE_NOACK = 2'd1,
        MODE_RAW   = 2'd2
    } spp_mode_e;

    typedef enum logic [2:0] {
        RX_SYNC, RX_CMD, RX_SN, RX_LHI, RX_LLO, RX_DATA, RX_CKH, RX_CKL
    } rx_state_e;

    typedef enum logic [3:0] {
        TX_IDLE, TX_LEAD, TX_SYNC, TX_CMD, TX_SN, TX_LHI, TX_LLO,
        TX_DATA, TX_CKH, TX_CKL
    } tx_state_e;
endpackage

// File: rtl/spp_rx_parse.sv
module spp_rx_parse
    import spp_pkg::*;
#(
    parameter int MAX_LEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw,
    input  logic             sel_active,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    output logic             pay_valid,
    output logic [7:0]       pay_byte,
    output logic             pkt_ok,
    output logic             pkt_err,
    output logic [7:0]       pkt_cmd,
    output logic [7:0]       pkt_sn
);
    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);

    rx_state_e        st, st_n;
    logic [7:0]       h_cmd, h_sn, len_hi, ck_hi;
    logic [LEN_W-1:0] h_len, cnt;
    logic [15:0]      sum;
    logic             take;
    logic [LEN_W-1:0] size_now;
    logic             too_big, ck_match;

    assign take     = sel_active && rx_valid && !raw;
    assign size_now = {len_hi, rx_byte};
    assign too_big  = size_now > MAX_L;
    assign ck_match = ({ck_hi, rx_byte} == sum);

    always_comb begin
        st_n = st;
        if (!sel_active || raw) begin
            st_n = RX_SYNC;
        end else if (rx_valid) begin
            unique case (st)
                RX_SYNC: st_n = (rx_byte == SYNC_BYTE) ? RX_CMD : RX_SYNC;
                RX_CMD:  st_n = RX_SN;
                RX_SN:   st_n = RX_LHI;
                RX_LHI:  st_n = RX_LLO;
                RX_LLO: begin
                    if (too_big)             st_n = RX_SYNC;
                    else if (size_now == '0) st_n = RX_CKH;
                    else                     st_n = RX_DATA;
                end
                RX_DATA: st_n = (cnt == h_len - LEN_W'(1)) ? RX_CKH : RX_DATA;
                RX_CKH:  st_n = RX_CKL;
                RX_CKL:  st_n = RX_SYNC;
                default: st_n = RX_SYNC;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_SYNC;
        else        st <= st_n;
    end

    // header capture and running checksum
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_cmd  <= '0;
            h_sn   <= '0;
            len_hi <= '0;
            ck_hi  <= '0;
            h_len  <= '0;
            cnt    <= '0;
            sum    <= '0;
        end else if (take) begin
            unique case (st)
                RX_SYNC: sum <= {8'h00, SYNC_BYTE};
                RX_CMD:  begin h_cmd  <= rx_byte; sum <= sum + 16'(rx_byte); end
                RX_SN:   begin h_sn   <= rx_byte; sum <= sum + 16'(rx_byte); end
                RX_LHI:  begin len_hi <= rx_byte; sum <= sum + 16'(rx_byte); end
                RX_LLO:  begin
                    h_len <= size_now;
                    cnt   <= '0;
                    sum   <= sum + 16'(rx_byte);
                end
                RX_DATA: begin cnt <= cnt + LEN_W'(1); sum <= sum + 16'(rx_byte); end
                RX_CKH:  ck_hi <= rx_byte;
                RX_CKL:  ;
                default: ;
            endcase
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pay_valid <= 1'b0;
            pay_byte  <= '0;
            pkt_ok    <= 1'b0;
            pkt_err   <= 1'b0;
            pkt_cmd   <= '0;
            pkt_sn    <= '0;
        end else begin
            pay_valid <= sel_active && rx_valid && (raw || st == RX_DATA);
            if (sel_active && rx_valid) pay_byte <= rx_byte;
            pkt_ok  <= take && (st == RX_CKL) && ck_match;
            pkt_err <= take && (((st == RX_SYNC) && (rx_byte != SYNC_BYTE)) ||
                                ((st == RX_LLO) && too_big) ||
                                ((st == RX_CKL) && !ck_match));
            if (take && st == RX_CKL && ck_match) begin
                pkt_cmd <= h_cmd;
                pkt_sn  <= h_sn;
            end
        end
    end
endmodule

// File: rtl/spp_ack_slot.sv
module spp_ack_slot (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       full_mode,
    input  logic       pkt_ok,
    input  logic [7:0] pkt_sn,
    input  logic       ack_take,
    output logic       ack_pend,
    output logic [7:0] ack_sn
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_pend <= 1'b0;
            ack_sn   <= '0;
        end else if (pkt_ok && full_mode) begin
            ack_pend <= 1'b1;
            ack_sn   <= pkt_sn;
        end else if (ack_take) begin
            ack_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/spp_tx_frame.sv
module spp_tx_frame
    import spp_pkg::*;
#(
    parameter logic [7:0] ACK_CMD = 8'hAC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw,
    input  logic             ack_pend,
    input  logic [7:0]       ack_sn,
    output logic             ack_take,
    input  logic             tx_go,
    input  logic [7:0]       tx_cmd,
    input  logic [LEN_W-1:0] tx_len,
    output logic             tx_accept,
    input  logic             tx_take,
    output logic [7:0]       tx_byte,
    output logic             tx_busy,
    output logic [LEN_W-1:0] tx_pay_idx,
    input  logic [7:0]       tx_pay_byte
);
    tx_state_e        st, st_n;
    logic [7:0]       f_cmd, f_sn, seq;
    logic [LEN_W-1:0] f_len, idx;
    logic             f_raw;
    logic [15:0]      sum;
    logic             last_data;

    assign ack_take   = (st == TX_IDLE) && ack_pend;
    assign tx_accept  = (st == TX_IDLE) && !ack_pend && tx_go;
    assign tx_busy    = (st != TX_IDLE);
    assign tx_pay_idx = idx;
    assign last_data  = (idx == f_len - LEN_W'(1));

    always_comb begin
        st_n = st;
        unique case (st)
            TX_IDLE: if (ack_take || tx_accept) st_n = TX_LEAD;
            TX_LEAD: if (tx_take) begin
                if (f_raw) st_n = (f_len == '0) ? TX_IDLE : TX_DATA;
                else       st_n = TX_SYNC;
            end
            TX_SYNC: if (tx_take) st_n = TX_CMD;
            TX_CMD:  if (tx_take) st_n = TX_SN;
            TX_SN:   if (tx_take) st_n = TX_LHI;
            TX_LHI:  if (tx_take) st_n = TX_LLO;
            TX_LLO:  if (tx_take) st_n = (f_len == '0) ? TX_CKH : TX_DATA;
            TX_DATA: if (tx_take && last_data) st_n = f_raw ? TX_IDLE : TX_CKH;
            TX_CKH:  if (tx_take) st_n = TX_CKL;
            TX_CKL:  if (tx_take) st_n = TX_IDLE;
            default: st_n = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TX_IDLE;
        else        st <= st_n;
    end

    always_comb begin
        unique case (st)
            TX_IDLE: tx_byte = FILL_BYTE;
            TX_LEAD: tx_byte = LEAD_BYTE;
            TX_SYNC: tx_byte = SYNC_BYTE;
            TX_CMD:  tx_byte = f_cmd;
            TX_SN:   tx_byte = f_sn;
            TX_LHI:  tx_byte = f_len[15:8];
            TX_LLO:  tx_byte = f_len[7:0];
            TX_DATA: tx_byte = tx_pay_byte;
            TX_CKH:  tx_byte = sum[15:8];
            TX_CKL:  tx_byte = sum[7:0];
            default: tx_byte = FILL_BYTE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_cmd <= '0;
            f_sn  <= '0;
            f_len <= '0;
            f_raw <= 1'b0;
            idx   <= '0;
            sum   <= '0;
            seq   <= '0;
        end else if (st == TX_IDLE) begin
            if (ack_take) begin
                f_cmd <= ACK_CMD;
                f_sn  <= ack_sn;
                f_len <= '0;
                f_raw <= 1'b0;
                idx   <= '0;
                sum   <= '0;
            end else if (tx_accept) begin
                f_cmd <= tx_cmd;
                f_sn  <= seq;
                f_len <= tx_len;
                f_raw <= raw;
                idx   <= '0;
                sum   <= '0;
                if (!raw) seq <= seq + 8'd1;
            end
        end else if (tx_take) begin
            if (st inside {TX_SYNC, TX_CMD, TX_SN, TX_LHI, TX_LLO, TX_DATA})
                sum <= sum + 16'(tx_byte);
            if (st == TX_DATA) idx <= idx + LEN_W'(1);
        end
    end
endmodule

// File: rtl/spp_link.sv
module spp_link
    import spp_pkg::*;
#(
    parameter int         MAX_LEN = 64,
    parameter logic [7:0] ACK_CMD = 8'hAC
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  mode,
    input  logic        sel_active,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    output logic        pay_valid,
    output logic [7:0]  pay_byte,
    output logic        pkt_ok,
    output logic        pkt_err,
    output logic [7:0]  pkt_cmd,
    output logic [7:0]  pkt_sn,
    input  logic        tx_go,
    input  logic [7:0]  tx_cmd,
    input  logic [15:0] tx_len,
    output logic        tx_accept,
    input  logic        tx_take,
    output logic [7:0]  tx_byte,
    output logic        tx_busy,
    output logic [15:0] tx_pay_idx,
    input  logic [7:0]  tx_pay_byte
);
    logic       raw, full_mode;
    logic       ack_pend, ack_take;
    logic [7:0] ack_sn;

    assign raw       = mode[1];
    assign full_mode = (mode == MODE_FULL);

    spp_rx_parse #(.MAX_LEN(MAX_LEN)) u_rx (
        .clk(clk), .rst_n(rst_n), .raw(raw), .sel_active(sel_active),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .pay_valid(pay_valid), .pay_byte(pay_byte),
        .pkt_ok(pkt_ok), .pkt_err(pkt_err), .pkt_cmd(pkt_cmd), .pkt_sn(pkt_sn)
    );

    spp_ack_slot u_ack (
        .clk(clk), .rst_n(rst_n), .full_mode(full_mode),
        .pkt_ok(pkt_ok), .pkt_sn(pkt_sn), .ack_take(ack_take),
        .ack_pend(ack_pend), .ack_sn(ack_sn)
    );

    spp_tx_frame #(.ACK_CMD(ACK_CMD)) u_tx (
        .clk(clk), .rst_n(rst_n), .raw(raw),
        .ack_pend(ack_pend), .ack_sn(ack_sn), .ack_take(ack_take),
        .tx_go(tx_go), .tx_cmd(tx_cmd), .tx_len(tx_len), .tx_accept(tx_accept),
        .tx_take(tx_take), .tx_byte(tx_byte), .tx_busy(tx_busy),
        .tx_pay_idx(tx_pay_idx), .tx_pay_byte(tx_pay_byte)
    );
endmodule

// File: rtl/spp_link_chk.sv
module spp_link_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       sel_active,
    input logic       rx_valid,
    input logic       pay_valid,
    input logic       pkt_ok,
    input logic       pkt_err,
    input logic       tx_accept,
    input logic       tx_take,
    input logic       tx_busy,
    input logic [7:0] tx_byte,
    input logic [7:0] tx_pay_byte
);
    p_ok_err_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_ok && pkt_err));

    p_raw_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode[1]) |-> (!pkt_ok && !pkt_err));

    p_pay_follows_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid |-> $past(rx_valid && sel_active));

    p_ok_follows_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_ok |-> $past(rx_valid && sel_active));

    p_deselect_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_active |=> (!pay_valid && !pkt_ok && !pkt_err));

    p_lead_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_accept |=> (tx_busy && tx_byte == 8'h00));

    p_idle_filler_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> (tx_byte == 8'hFF));

    p_hold_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && !tx_take) |=> ($stable(tx_byte) || !$stable(tx_pay_byte)));
endmodule

bind spp_link spp_link_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sel_active(sel_active),
    .rx_valid(rx_valid), .pay_valid(pay_valid), .pkt_ok(pkt_ok),
    .pkt_err(pkt_err), .tx_accept(tx_accept), .tx_take(tx_take),
    .tx_busy(tx_busy), .tx_byte(tx_byte), .tx_pay_byte(tx_pay_byte)
);

// File: tb/tb_spp_link.sv
module tb_spp_link;
    typedef logic [7:0] byte_t;
    localparam int         MAX_LEN = 64;
    localparam logic [7:0] ACK_CMD = 8'hAC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        sel_active = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        pay_valid, pkt_ok, pkt_err, tx_accept, tx_busy;
    logic [7:0]  pay_byte, pkt_cmd, pkt_sn, tx_byte, tx_pay_byte;
    logic        tx_go = 1'b0;
    logic [7:0]  tx_cmd = '0;
    logic [15:0] tx_len = '0;
    logic        tx_take = 1'b0;
    logic [15:0] tx_pay_idx;

    byte_t pmem [64];
    assign tx_pay_byte = pmem[tx_pay_idx[5:0]];

    always #4 clk = ~clk;

    spp_link #(.MAX_LEN(MAX_LEN), .ACK_CMD(ACK_CMD)) dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .sel_active(sel_active),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .pay_valid(pay_valid), .pay_byte(pay_byte),
        .pkt_ok(pkt_ok), .pkt_err(pkt_err), .pkt_cmd(pkt_cmd), .pkt_sn(pkt_sn),
        .tx_go(tx_go), .tx_cmd(tx_cmd), .tx_len(tx_len), .tx_accept(tx_accept),
        .tx_take(tx_take), .tx_byte(tx_byte), .tx_busy(tx_busy),
        .tx_pay_idx(tx_pay_idx), .tx_pay_byte(tx_pay_byte)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int n_ok = 0;
    int n_err = 0;
    byte_t last_cmd, last_sn;
    byte_t payq[$];
    byte_t pktq[$];
    byte_t expq[$];
    byte_t expf[$];
    int    exp_seq = 0;

    always @(negedge clk) begin
        if (pkt_ok)    begin n_ok++; last_cmd = pkt_cmd; last_sn = pkt_sn; end
        if (pkt_err)   n_err++;
        if (pay_valid) payq.push_back(pay_byte);
    end

    task automatic chk(input string r, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    function automatic logic [15:0] sum16(input byte_t q[$]);
        logic [15:0] s = '0;
        foreach (q[i]) s = s + 16'(q[i]);
        return s;
    endfunction

    task automatic clear_obs();
        n_ok = 0; n_err = 0; payq.delete();
    endtask

    task automatic send_q(input byte_t q[$]);
        foreach (q[i]) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_byte  = q[i];
        end
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic deselect();
        @(negedge clk); sel_active = 1'b0;
        @(negedge clk); sel_active = 1'b1;
    endtask

    // kind: 0 good, 1 bad checksum
    task automatic build_pkt(input byte_t cmd, input byte_t sn, input int len, input int kind);
        logic [15:0] s;
        pktq.delete(); expq.delete();
        pktq.push_back(8'h5A); pktq.push_back(cmd); pktq.push_back(sn);
        pktq.push_back(byte_t'(len >> 8)); pktq.push_back(byte_t'(len));
        for (int i = 0; i < len; i++) begin
            byte_t b = byte_t'($urandom);
            pktq.push_back(b); expq.push_back(b);
        end
        s = sum16(pktq);
        if (kind == 1) s = s ^ 16'h0001;
        pktq.push_back(s[15:8]); pktq.push_back(s[7:0]);
    endtask

    task automatic read_frame(input string r, input byte_t ef[$]);
        byte_t got[$];
        int k = 0;
        bit same;
        while (!tx_busy && k < 20) begin @(negedge clk); k++; end
        foreach (ef[i]) begin
            @(negedge clk);
            tx_take = 1'b0;
            got.push_back(tx_byte);
            tx_take = 1'b1;
        end
        @(negedge clk);
        tx_take = 1'b0;
        same = 1'b1;
        foreach (ef[i]) if (got[i] != ef[i]) begin
            if (same) chk({r, " frame byte"}, int'(got[i]), int'(ef[i]));
            same = 1'b0;
        end
        if (same) chk({r, " frame"}, 0, 0);
        chk({r, " R11 busy after frame"}, int'(tx_busy), 0);
    endtask

    function automatic void ack_frame(input byte_t sn);
        byte_t h[$];
        logic [15:0] s;
        h = '{8'h5A, ACK_CMD, sn, 8'h00, 8'h00};
        s = sum16(h);
        expf = '{8'h00};
        foreach (h[i]) expf.push_back(h[i]);
        expf.push_back(s[15:8]); expf.push_back(s[7:0]);
    endfunction

    function automatic void data_frame(input byte_t cmd, input byte_t sn, input int len);
        byte_t h[$];
        logic [15:0] s;
        h = '{8'h5A, cmd, sn, byte_t'(len >> 8), byte_t'(len)};
        for (int i = 0; i < len; i++) h.push_back(pmem[i]);
        s = sum16(h);
        expf = '{8'h00};
        foreach (h[i]) expf.push_back(h[i]);
        expf.push_back(s[15:8]); expf.push_back(s[7:0]);
    endfunction

    task automatic request(input byte_t cmd, input int len);
        tx_cmd = cmd; tx_len = 16'(len); tx_go = 1'b1;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (tx_accept) break;
        end
        @(negedge clk);
        tx_go = 1'b0;
    endtask

    task automatic fill_mem();
        for (int i = 0; i < 64; i++) pmem[i] = byte_t'($urandom);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 190000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int kind, len;
        byte_t sn, cmd;
        void'($urandom(32'd1234));
        fill_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 tx_busy", int'(tx_busy), 0);
        chk("R10 tx_byte filler", int'(tx_byte), 8'hFF);
        chk("R10 pulses", int'({pay_valid, pkt_ok, pkt_err}), 0);
        sel_active = 1'b1;

        // R12 zero-length good packet, R4 ack
        clear_obs();
        build_pkt(8'h11, 8'h42, 0, 0);
        send_q(pktq);
        @(negedge clk);
        chk("R12 zero-length ok", n_ok, 1);
        chk("R2 sn", int'(last_sn), 8'h42);
        chk("R2 cmd", int'(last_cmd), 8'h11);
        ack_frame(8'h42);
        read_frame("R4 ack", expf);

        // R1/R2/R3/R4 random packets in full mode
        for (int p = 0; p < 40; p++) begin
            kind = $urandom_range(0, 3);
            len  = $urandom_range(0, MAX_LEN);
            sn   = byte_t'($urandom);
            cmd  = byte_t'($urandom);
            clear_obs();
            if (kind <= 1) begin
                build_pkt(cmd, sn, len, kind);
                send_q(pktq);
                @(negedge clk);
                chk(kind == 0 ? "R2 good ok" : "R3 bad ck ok", n_ok, kind == 0 ? 1 : 0);
                chk(kind == 0 ? "R2 good err" : "R3 bad ck err", n_err, kind == 0 ? 0 : 1);
                chk("R1 payload count", payq.size(), expq.size());
                if (payq.size() == expq.size())
                    foreach (expq[i]) if (payq[i] != expq[i]) begin
                        chk("R1 payload byte", int'(payq[i]), int'(expq[i]));
                        break;
                    end
                if (kind == 0) begin
                    chk("R2 sn", int'(last_sn), int'(sn));
                    ack_frame(sn);
                    read_frame("R4 ack", expf);
                end else begin
                    repeat (3) @(negedge clk);
                    chk("R3 no ack after bad ck", int'(tx_busy), 0);
                end
            end else if (kind == 2) begin
                int big = MAX_LEN + 1 + $urandom_range(0, 300);
                send_q('{8'h5A, cmd, sn, byte_t'(big >> 8), byte_t'(big)});
                @(negedge clk);
                chk("R3 oversize err", n_err, 1);
                chk("R3 oversize ok", n_ok, 0);
                deselect();
            end else begin
                send_q('{8'h5B});
                @(negedge clk);
                chk("R3 bad sync err", n_err, 1);
            end
        end

        // R9 abort mid-packet then clean packet
        clear_obs();
        send_q('{8'h5A, 8'h01, 8'h02, 8'h00, 8'h04, 8'h10});
        deselect();
        chk("R9 no pulse on abort", n_ok + n_err, 0);
        clear_obs();
        build_pkt(8'h22, 8'h77, 3, 0);
        send_q(pktq);
        @(negedge clk);
        chk("R9 next packet ok", n_ok, 1);
        chk("R9 next packet err", n_err, 0);
        ack_frame(8'h77);
        read_frame("R9 ack", expf);

        // R7 data frame, R11 hold while not taken
        fill_mem();
        request(8'h31, 5);
        repeat (4) @(negedge clk);
        chk("R11 lead held", int'(tx_byte), 8'h00);
        data_frame(8'h31, byte_t'(exp_seq), 5); exp_seq++;
        read_frame("R7 data", expf);

        // R8 ack precedence
        request(8'h32, 2);
        data_frame(8'h32, byte_t'(exp_seq), 2); exp_seq++;
        begin
            byte_t first[$];
            first = expf;
            build_pkt(8'h44, 8'h9C, 1, 0);
            send_q(pktq);
            tx_cmd = 8'h33; tx_len = 16'd1; tx_go = 1'b1;
            read_frame("R8 data in flight", first);
            ack_frame(8'h9C);
            read_frame("R8 ack before data", expf);
            for (int k = 0; k < 50; k++) begin
                @(negedge clk);
                if (tx_accept) break;
            end
            @(negedge clk); tx_go = 1'b0;
            data_frame(8'h33, byte_t'(exp_seq), 1); exp_seq++;
            read_frame("R8 data after ack", expf);
        end

        // R5 no-ack mode
        mode = 2'd1;
        clear_obs();
        build_pkt(8'h55, 8'h12, 4, 0);
        send_q(pktq);
        @(negedge clk);
        chk("R5 parse ok", n_ok, 1);
        repeat (4) @(negedge clk);
        chk("R5 no ack queued", int'(tx_busy), 0);

        // R6 raw mode
        mode = 2'd2;
        @(negedge clk);
        clear_obs();
        send_q('{8'h5A, 8'h00, 8'hC3, 8'h5A, 8'h7E});
        @(negedge clk);
        chk("R6 raw forward count", payq.size(), 5);
        if (payq.size() == 5) chk("R6 raw byte", int'(payq[2]), 8'hC3);
        chk("R6 raw no pulses", n_ok + n_err, 0);
        request(8'h99, 3);
        expf = '{8'h00, pmem[0], pmem[1], pmem[2]};
        read_frame("R6 raw tx", expf);

        // R7 sequence continues after raw, and wraps
        mode = 2'd1;
        @(negedge clk);
        for (int p = 0; p < 257; p++) begin
            request(8'h60, 0);
            data_frame(8'h60, byte_t'(exp_seq), 0); exp_seq++;
            read_frame("R7 seq", expf);
        end

        finish_run();
    end
endmodule